// File: doc/BRIEF.md
# Multi-Cycled 2D Convolution MAC

This block forms the weighted sum of an image window against a stored kernel of signed 8-bit weights and delivers one result per pixel period. A fixed row of `NMUL` multipliers is time-shared: in one-beat mode each pixel period covers `NMUL` window positions, in two-beat mode it covers `2*NMUL` positions, and in four-beat mode it covers `4*NMUL` positions. A slower pixel rate therefore buys a larger window. With the default `NMUL = 16` the four-beat mode covers a full 8x8 window of 8-bit pixels.

Window pixels arrive on a valid/ready input stream. Each accepted beat carries one slice of `NMUL` unsigned pixels, taken from the line-delay taps upstream. The accumulator clears on the first beat of a pixel period and closes on the last. A cascade input, sampled on the last beat, is added to the local sum so that several units can be chained into a wider window. The full 32-bit total leaves on `out_wide`, ready to feed the next unit's cascade input. A left-shift gain stage with saturation places the significant bits into the 16-bit `out_data` word.

Back-pressure rules: a result is held on `out_valid`, `out_data` and `out_wide` until `out_ready` is high at a clock edge. While a result is held and `out_ready` is low, the pipeline stops and `in_ready` is low. An input beat transfers at an edge where `in_valid` and `in_ready` are both high. The kernel is loaded through a plain write port. That port is honoured only while the engine is idle or held in reset.

Top module: `conv_mac_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `cfg_mode` sets the beats per pixel period: 0 gives 1 beat, 1 gives 2 beats, and 2 or 3 gives 4 beats. Lane `l` of beat `b` is `in_pix[l*PIX_W +: PIX_W]` and is weighted by the coefficient at address `b*NMUL + l`. Exactly one result is produced per pixel period.
- R3: Pixels are unsigned and coefficients are two's-complement signed. Products and their sum are formed at 32-bit precision, and the total wraps modulo 2^32.
- R4: `in_casc` is sampled on the last beat of a pixel period and added to that period's sum. Its value on other beats has no effect.
- R5: `out_wide` carries the full 32-bit total (sum plus cascade) before the gain stage.
- R6: With gain `g` (0 to 31), when the total shifted left by `g` still fits a signed 32-bit value, `out_data` is bits 31:16 of the shifted total.
- R7: When the shifted total does not fit, `out_data` saturates to 16'h7FFF for a non-negative total and 16'h8000 for a negative one.
- R8: With `out_ready` held high, `out_valid` rises exactly two clock edges after the edge that accepts the last beat of a pixel period.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid`, `out_data` and `out_wide` stay unchanged.
- R10: A coefficient write (`cw_en`, `cw_addr`, `cw_data`) takes effect only if reset is asserted or the engine is idle. Idle means no beat offered, no pixel period in progress, and no result in flight or held. Otherwise the write is dropped.
- R11: `cfg_mode` and `cfg_gain` are sampled on the first beat of each pixel period. Changes to them on later beats of the same period have no effect on that period's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beat per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Beats per pixel period (0:1, 1:2, 2/3:4) |
| cfg_gain | input | 5 | Left-shift amount for the output gain stage |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_pix | input | NMUL*PIX_W | One slice of unsigned window pixels |
| in_casc | input | 32 | Cascade sum from the previous unit |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | log2(4*NMUL) | Coefficient address (beat*NMUL + lane) |
| cw_data | input | 8 | Signed coefficient value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 16 | Gain-aligned, saturated result |
| out_wide | output | 32 | Full total for cascading |

## Verification
The bench builds the engine with `NMUL = 4` and 8-bit pixels. The whole 16-entry kernel is then reached in four-beat mode after a few beats, and every coefficient address is exercised in all three modes. Random gains from 0 to 31 with full-scale kernels reach both saturation levels as well as exact alignment. A stall phase with random `out_ready` covers the hold and input-blocking rules. A coefficient write issued in the middle of a pixel period, and mode or gain changes issued on later beats, show that such inputs are ignored.

// File: rtl/conv_pkg.sv
package conv_pkg;

  typedef enum logic [1:0] {
    MODE_X1 = 2'd0,
    MODE_X2 = 2'd1,
    MODE_X4 = 2'd2,
    MODE_X4B = 2'd3
  } beat_mode_e;

  function automatic logic [2:0] beats_of(input logic [1:0] mode);
    case (beat_mode_e'(mode))
      MODE_X1: beats_of = 3'd1;
      MODE_X2: beats_of = 3'd2;
      default: beats_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/conv_coef_bank.sv
module conv_coef_bank #(
  parameter int NMUL   = 16,
  parameter int COEF_W = 8,
  localparam int LW    = $clog2(NMUL),
  localparam int AW    = LW + 2,
  localparam int TAPS  = NMUL * 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ok,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [COEF_W-1:0]      wr_data,
  input  logic [1:0]             rd_sub,
  output logic [NMUL*COEF_W-1:0] rd_coef
);

  logic [COEF_W-1:0] mem [TAPS];

  always_ff @(posedge clk) begin
    if (wr_en && (!rst_n || wr_ok)) mem[wr_addr] <= wr_data;
  end

  for (genvar l = 0; l < NMUL; l++) begin : g_rd
    assign rd_coef[l*COEF_W +: COEF_W] = mem[{rd_sub, LW'(l)}];
  end

  // R10: a busy engine never sees its kernel change
  for (genvar t = 0; t < TAPS; t++) begin : g_chk
    p_no_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(mem[t]));
  end

endmodule

// File: rtl/conv_mul_row.sv
module conv_mul_row #(
  parameter int NMUL   = 16,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int PROD_W = PIX_W + COEF_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [NMUL*PIX_W-1:0]  pix,
  input  logic [NMUL*COEF_W-1:0] coef,
  output logic [NMUL*PROD_W-1:0] prod
);

  for (genvar l = 0; l < NMUL; l++) begin : g_lane
    logic signed [PIX_W:0]      px_s;
    logic signed [COEF_W-1:0]   cf_s;
    logic signed [PROD_W-1:0]   mul;

    assign px_s = {1'b0, pix[l*PIX_W +: PIX_W]};
    assign cf_s = coef[l*COEF_W +: COEF_W];
    assign mul  = PROD_W'(px_s * cf_s);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prod[l*PROD_W +: PROD_W] <= '0;
      else if (en) prod[l*PROD_W +: PROD_W] <= mul;
    end
  end

endmodule

// File: rtl/conv_acc.sv
module conv_acc #(
  parameter int NMUL   = 16,
  parameter int PROD_W = 17,
  parameter int ACC_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic                   in_last,
  input  logic [ACC_W-1:0]       in_casc,
  input  logic [NMUL*PROD_W-1:0] in_prod,
  output logic                   out_valid,
  output logic [ACC_W-1:0]       out_total
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] slice_sum;
  logic [ACC_W-1:0] running;

  always_comb begin
    slice_sum = '0;
    for (int l = 0; l < NMUL; l++) begin
      slice_sum = slice_sum + ACC_W'($signed(in_prod[l*PROD_W +: PROD_W]));
    end
    running = (in_first ? '0 : acc_q) + slice_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_total <= '0;
    end else if (adv) begin
      out_valid <= in_valid && in_last;
      if (in_valid) begin
        acc_q <= running;
        if (in_last) out_total <= running + in_casc;
      end
    end
  end

  // R2: a closing beat always yields a total on the next advance
  p_emit_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && in_last) |=> out_valid);

  // R2: beats that do not close a period yield nothing
  p_quiet_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !(in_valid && in_last)) |=> !out_valid);

endmodule

// File: rtl/conv_gain.sv
module conv_gain #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16,
  localparam int SH_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              out_ready,
  input  logic              in_valid,
  input  logic [ACC_W-1:0]  in_total,
  input  logic [SH_W-1:0]   in_gain,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_wide,
  output logic [OUT_W-1:0]  out_data
);

  logic [SH_W:0]           rsh;
  logic signed [ACC_W-1:0] hi;
  logic                    fits;
  logic [ACC_W-1:0]        shifted;
  logic [OUT_W-1:0]        sat_val;
  logic [OUT_W-1:0]        aligned;

  always_comb begin
    rsh     = (SH_W+1)'(ACC_W - 1) - {1'b0, in_gain};
    hi      = $signed(in_total) >>> rsh;
    fits    = (hi == '0) || (hi == '1);
    shifted = in_total << in_gain;
    sat_val = in_total[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                : {1'b0, {(OUT_W-1){1'b1}}};
    aligned = fits ? shifted[ACC_W-1 -: OUT_W] : sat_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wide  <= '0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_wide <= in_total;
        out_data <= aligned;
      end
    end
  end

  // R8: a finished total reaches the output on the next advance
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid) |=> out_valid);

  // R9: a refused result is held unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_wide)));

  // R7: gain and saturation never flip the sign of the result
  p_sign_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[OUT_W-1] == out_wide[ACC_W-1]));

endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine #(
  parameter int NMUL   = 16,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 16,
  localparam int AW     = $clog2(NMUL) + 2,
  localparam int SH_W   = $clog2(ACC_W),
  localparam int PROD_W = PIX_W + COEF_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic [SH_W-1:0]       cfg_gain,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NMUL*PIX_W-1:0] in_pix,
  input  logic [ACC_W-1:0]      in_casc,
  input  logic                  cw_en,
  input  logic [AW-1:0]         cw_addr,
  input  logic [COEF_W-1:0]     cw_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUT_W-1:0]      out_data,
  output logic [ACC_W-1:0]      out_wide
);
  import conv_pkg::*;

  // Beat sequencing
  logic                   adv, fire, last_beat, idle;
  logic [1:0]             sub_q;
  logic [2:0]             beats_q, beats_cur;
  logic [SH_W-1:0]        gain_q, gain_cur;

  // Stage 1 (products) side information
  logic                   v1, first1, last1;
  logic [ACC_W-1:0]       casc1;
  logic [SH_W-1:0]        gain1;

  // Stage 2 (totals)
  logic                   v2;
  logic [ACC_W-1:0]       tot2;
  logic [SH_W-1:0]        gain2;

  logic [NMUL*COEF_W-1:0] coef_slice;
  logic [NMUL*PROD_W-1:0] prod1;

  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;
  assign fire      = in_valid && adv;
  assign beats_cur = (sub_q == 2'd0) ? beats_of(cfg_mode) : beats_q;
  assign gain_cur  = (sub_q == 2'd0) ? cfg_gain : gain_q;
  assign last_beat = ({1'b0, sub_q} == beats_cur - 3'd1);
  assign idle      = (sub_q == 2'd0) && !in_valid && !v1 && !v2 && !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= 2'd0;
      beats_q <= 3'd1;
      gain_q  <= '0;
    end else if (fire) begin
      sub_q <= last_beat ? 2'd0 : sub_q + 2'd1;
      if (sub_q == 2'd0) begin
        beats_q <= beats_cur;
        gain_q  <= cfg_gain;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      first1 <= 1'b0;
      last1  <= 1'b0;
      casc1  <= '0;
      gain1  <= '0;
      gain2  <= '0;
    end else if (adv) begin
      v1     <= fire;
      first1 <= (sub_q == 2'd0);
      last1  <= last_beat;
      casc1  <= in_casc;
      gain1  <= gain_cur;
      gain2  <= gain1;
    end
  end

  conv_coef_bank #(.NMUL(NMUL), .COEF_W(COEF_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (idle),
    .wr_en   (cw_en),
    .wr_addr (cw_addr),
    .wr_data (cw_data),
    .rd_sub  (sub_q),
    .rd_coef (coef_slice)
  );

  conv_mul_row #(.NMUL(NMUL), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .pix   (in_pix),
    .coef  (coef_slice),
    .prod  (prod1)
  );

  conv_acc #(.NMUL(NMUL), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (v1),
    .in_first  (first1),
    .in_last   (last1),
    .in_casc   (casc1),
    .in_prod   (prod1),
    .out_valid (v2),
    .out_total (tot2)
  );

  conv_gain #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .out_ready (out_ready),
    .in_valid  (v2),
    .in_total  (tot2),
    .in_gain   (gain2),
    .out_valid (out_valid),
    .out_wide  (out_wide),
    .out_data  (out_data)
  );

  // R9: a stalled output blocks new beats
  p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2: the beat counter never passes the period length it latched
  p_sub_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q != 2'd0) |-> ({1'b0, sub_q} < beats_q));

  // R11: settings latched for a period hold until it closes
  p_cfg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q != 2'd0) |=> ((sub_q == 2'd0) || ($stable(beats_q) && $stable(gain_q))));

endmodule

// File: tb/sim_conv_mac_engine.sv
module sim_conv_mac_engine;
  localparam int N    = 4;
  localparam int PW   = 8;
  localparam int TAPS = N * 4;
  localparam int AW   = 4;

  typedef struct {
    logic [31:0] w;
    logic [15:0] d;
    bit          sat;
    string       tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    cfg_mode = 0;
  logic [4:0]    cfg_gain = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [N*PW-1:0] in_pix = 0;
  logic [31:0]   in_casc = 0;
  logic          cw_en = 0;
  logic [AW-1:0] cw_addr = 0;
  logic [7:0]    cw_data = 0;
  logic          out_valid;
  logic          out_ready = 1;
  logic [15:0]   out_data;
  logic [31:0]   out_wide;

  int   checks = 0;
  int   errors = 0;
  bit   bp = 0;
  bit   done = 0;
  int   cm [TAPS];
  exp_t q [$];

  always #5 clk = ~clk;

  conv_mac_engine #(.NMUL(N), .PIX_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_gain(cfg_gain),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_casc(in_casc),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_wide(out_wide)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] align(input logic [31:0] t, input int g, output bit sat);
    longint s;
    s = longint'($signed(t)) <<< g;
    sat = 1;
    if (s > 64'sd2147483647) return 16'h7fff;
    if (s < -64'sd2147483648) return 16'h8000;
    sat = 0;
    return s[31:16];
  endfunction

  // Drive one coefficient write for a single cycle
  task automatic cwrite(input int a, input int v);
    @(negedge clk);
    cw_en = 1; cw_addr = AW'(a); cw_data = 8'(v);
    @(negedge clk);
    cw_en = 0;
  endtask

  // Driver: builds a pixel period, pushes its expected result, then drives the beats
  task automatic send_pixel(input int m, input int g, input bit mid_cfg,
                            input bit mid_wr, input string tag);
    int    nb;
    int    px [4][N];
    logic [31:0] casc, tot;
    exp_t  e;
    bit    ok;
    nb = (m == 0) ? 1 : (m == 1) ? 2 : 4;
    casc = $urandom;
    tot = 0;
    for (int b = 0; b < nb; b++)
      for (int l = 0; l < N; l++) begin
        px[b][l] = int'($urandom % 256);
        tot = tot + 32'(px[b][l] * cm[b*N + l]);
      end
    tot = tot + casc;
    e.w = tot;
    e.d = align(tot, g, e.sat);
    e.tag = tag;
    q.push_back(e);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      in_valid = 1;
      for (int l = 0; l < N; l++) in_pix[l*PW +: PW] = PW'(px[b][l]);
      in_casc = (b == nb - 1) ? casc : $urandom;
      if (b == 0) begin
        cfg_mode = 2'(m); cfg_gain = 5'(g);
      end else if (mid_cfg) begin
        cfg_mode = 2'(m == 0 ? 2 : 0); cfg_gain = 5'(g ^ 5'h15);
      end
      if (mid_wr && b == 1) begin
        cw_en = 1; cw_addr = 4'd5; cw_data = 8'h55;
      end
      forever begin
        #1 ok = in_ready;
        @(posedge clk);
        if (ok) break;
        @(negedge clk);
      end
      cw_en = 0;
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    idle_in();
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  // Downstream acceptance pattern
  initial begin
    forever begin
      @(posedge clk);
      #2 out_ready = bp ? 1'($urandom % 2) : 1'b1;
    end
  end

  // Monitor: compares results as they transfer, and checks hold behaviour
  initial begin
    bit          prev_stall = 0;
    logic [15:0] pd;
    logic [31:0] pw;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid && out_data == pd && out_wide == pw, "R9 hold",
              {out_data, out_wide}, {pd, pw});
        end
        prev_stall = out_valid && !out_ready;
        if (prev_stall) begin
          pd = out_data; pw = out_wide;
          chk(!in_ready, "R9 in_ready", in_ready, 0);
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            chk(0, "R2 unexpected result", out_wide, 0);
          end else begin
            e = q.pop_front();
            chk(out_wide == e.w, {e.tag, " R3 R4 R5 wide"}, out_wide, e.w);
            chk(out_data == e.d, {e.tag, e.sat ? " R7 data" : " R6 data"}, out_data, e.d);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: kernel loaded while reset is held
    for (int t = 0; t < TAPS; t++) begin
      cm[t] = int'($urandom % 256) - 128;
      cwrite(t, cm[t]);
    end
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 in reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R2 R3: every mode, no gain
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++) send_pixel(m, 0, 0, 0, "R2");
    drain();

    // R8: latency with out_ready high
    send_pixel(0, 0, 0, 0, "R8");
    idle_in();
    chk(out_valid == 0, "R8 edge+1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 0, "R8 edge+2 pending", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R8 edge+2", out_valid, 1);
    drain();

    // R6 R7: random gains across modes
    for (int k = 0; k < 24; k++) send_pixel(k % 3, int'($urandom % 32), 0, 0, "R6");
    drain();

    // R7: full-scale kernels, both signs
    for (int t = 0; t < TAPS; t++) begin cm[t] = 127; cwrite(t, 127); end
    for (int g = 18; g < 22; g++) send_pixel(2, g, 0, 0, "R7 pos");
    drain();
    for (int t = 0; t < TAPS; t++) begin cm[t] = -128; cwrite(t, -128); end
    for (int g = 18; g < 22; g++) send_pixel(2, g, 0, 0, "R7 neg");
    drain();
    for (int t = 0; t < TAPS; t++) begin
      cm[t] = int'($urandom % 256) - 128;
      cwrite(t, cm[t]);
    end

    // R11: mode and gain changed on later beats
    for (int k = 0; k < 4; k++) send_pixel(1 + (k % 2) * 1, 8 + k, 1, 0, "R11");
    drain();

    // R10: write during a period is dropped, model keeps old value
    send_pixel(2, 4, 0, 1, "R10 busy");
    drain();
    send_pixel(2, 4, 0, 0, "R10 after busy");
    drain();
    cm[5] = 8'sh55;
    cwrite(5, 8'h55);
    send_pixel(2, 4, 0, 0, "R10 idle");
    drain();

    // R9: random back-pressure
    bp = 1;
    for (int k = 0; k < 40; k++) send_pixel(k % 4, int'($urandom % 32), 0, 0, "R9");
    idle_in();
    wait (q.size() == 0);
    bp = 0;
    repeat (6) @(negedge clk);
    chk(q.size() == 0 && out_valid == 0, "R2 all results seen", q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule